// File: doc/BRIEF.md
# Sticky Overflow Arithmetic Unit

This block is a small signed arithmetic unit that keeps an overflow flag. Each clock it may accept one operation: add, subtract, absolute value or compare. The operation works either on the full 32-bit accumulator width or on a 16-bit register width. The result is registered. Any signed overflow raises a status flag, and that flag stays raised until it is explicitly cleared.

The flag is cleared only by reset or by a branch-test strobe. The strobe models a conditional branch that examines the flag and clears it whether or not the branch is taken. Compare operations never disturb the flag or the result. The flag is also presented at bit 6 of a status word, so that surrounding logic can read it as part of a wider status register.

Top module: `sticky_ovf_alu`

## Requirements
- R1: An add (op_code 2'b00, result = a + b) with wide_mode=1 whose true signed result lies outside -2^31..2^31-1 sets ovf_flag. The result register takes the two's-complement wrapped 32-bit value. Both appear one clock after the operation is sampled.
- R2: A subtract (op_code 2'b01, result = a - b) sets ovf_flag when its true signed result leaves the range of the selected width. Otherwise it leaves the flag unchanged.
- R3: With wide_mode=0, only bits 15:0 of each operand are used. The range for overflow is -2^15..2^15-1, and the result is the wrapped 16-bit value sign-extended to 32 bits. A sum that overflows 16 bits but fits in 32 bits sets the flag only when wide_mode=0.
- R4: Once set, ovf_flag stays 1 through any later operation that does not overflow, and through idle cycles.
- R5: br_test high in a cycle makes ovf_flag 0 in the next cycle, whatever the previous flag value. This clear takes priority over an overflow in the same cycle. The result of that same-cycle operation is still written.
- R6: A compare (op_code 2'b11) changes neither ovf_flag nor result, for any operands.
- R7: Absolute value (op_code 2'b10, operand a) of the most negative value of the selected width (0x80000000, or 0x8000 in 16-bit mode) returns that value unchanged and sets ovf_flag. Absolute value of any other value returns its magnitude and does not set the flag.
- R8: status_word bit 6 always equals ovf_flag, and every other status_word bit is 0.
- R9: After reset, result, ovf_flag and status_word are all 0.
- R10: When op_valid is 0, result and ovf_flag keep their values, whatever the operands and op_code are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation valid strobe |
| op_code | input | 2 | 00 add, 01 subtract, 10 absolute value, 11 compare |
| wide_mode | input | 1 | 1 selects 32-bit accumulator width, 0 selects 16-bit width |
| opnd_a | input | 32 | First operand (minuend, absolute-value source) |
| opnd_b | input | 32 | Second operand |
| br_test | input | 1 | Branch-tests-flag strobe; clears the flag |
| result | output | 32 | Registered result |
| ovf_flag | output | 1 | Sticky overflow flag |
| status_word | output | 16 | Status word holding the flag at bit 6 |

## Verification
Every effect of a stimulus sampled at a rising edge is due one cycle later. The result and ovf_flag both come from registers, and status_word follows the flag with no further delay. The bench therefore drives each cycle's inputs on the falling edge and queues the expected outputs for that cycle. It compares them 1 ns after the next rising edge, so each queued item meets exactly the edge that registered it. Idle and clearing cycles also queue an item, which keeps the queue aligned cycle for cycle and shows that held values really stay held.

// File: rtl/sovf_pkg.sv
package sovf_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_ABS = 2'b10,
      OP_CMP = 2'b11
   } sovf_op_e;
endpackage

// File: rtl/sovf_lane.sv
module sovf_lane
   import sovf_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  sovf_op_e     op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         ovf
);
   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_w
         $error("sovf_lane: W must be at least 2");
      end
   endgenerate

   always_comb begin
      y   = '0;
      ovf = 1'b0;
      unique case (op)
         OP_ADD: begin
            y   = a + b;
            ovf = (a[MSB] == b[MSB]) && (y[MSB] != a[MSB]);
         end
         OP_SUB: begin
            y   = a - b;
            ovf = (a[MSB] != b[MSB]) && (y[MSB] != a[MSB]);
         end
         OP_ABS: begin
            y   = a[MSB] ? (~a + 1'b1) : a;
            ovf = a[MSB] && y[MSB];
         end
         default: begin
            y   = '0;
            ovf = 1'b0;
         end
      endcase
   end

   // Independent check: one extra sign bit shows whether the value fits.
   logic [W:0] ext_sum, ext_dif;
   assign ext_sum = {a[MSB], a} + {b[MSB], b};
   assign ext_dif = {a[MSB], a} - {b[MSB], b};

   assert_add_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ADD) |-> (ovf == (ext_sum[W] != ext_sum[MSB])));
   assert_sub_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SUB) |-> (ovf == (ext_dif[W] != ext_dif[MSB])));
   assert_abs_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ABS) |-> (ovf == (a == {1'b1, {MSB{1'b0}}})));
endmodule

// File: rtl/sovf_sticky.sv
module sovf_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (clr_i) q <= 1'b0;
      else if (set_i) q <= 1'b1;
   end

   assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i) |=> q);
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr_i) |=> q);
   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !q);
   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!q && !set_i) |=> !q);
endmodule

// File: rtl/sticky_ovf_alu.sv
module sticky_ovf_alu
   import sovf_pkg::*;
#(
   parameter int ACC_W    = 32,
   parameter int REG_W    = 16,
   parameter int STAT_W   = 16,
   parameter int FLAG_POS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op_code,
   input  logic              wide_mode,
   input  logic [ACC_W-1:0]  opnd_a,
   input  logic [ACC_W-1:0]  opnd_b,
   input  logic              br_test,
   output logic [ACC_W-1:0]  result,
   output logic              ovf_flag,
   output logic [STAT_W-1:0] status_word
);
   localparam int EXT_W = ACC_W - REG_W;

   generate
      if (REG_W >= ACC_W) begin : g_bad_width
         $error("sticky_ovf_alu: REG_W must be narrower than ACC_W");
      end
      if (FLAG_POS >= STAT_W) begin : g_bad_pos
         $error("sticky_ovf_alu: FLAG_POS must lie inside the status word");
      end
   endgenerate

   sovf_op_e op;
   assign op = sovf_op_e'(op_code);

   logic [ACC_W-1:0] y_wide;
   logic [REG_W-1:0] y_nar;
   logic             ovf_wide, ovf_nar;

   sovf_lane #(.W(ACC_W)) u_lane_wide (
      .clk(clk), .rst_n(rst_n), .op(op),
      .a(opnd_a), .b(opnd_b), .y(y_wide), .ovf(ovf_wide)
   );

   sovf_lane #(.W(REG_W)) u_lane_nar (
      .clk(clk), .rst_n(rst_n), .op(op),
      .a(opnd_a[REG_W-1:0]), .b(opnd_b[REG_W-1:0]), .y(y_nar), .ovf(ovf_nar)
   );

   logic             writes;
   logic             ovf_hit;
   logic [ACC_W-1:0] res_next;

   assign writes   = op_valid && (op != OP_CMP);
   assign ovf_hit  = writes && (wide_mode ? ovf_wide : ovf_nar);
   assign res_next = wide_mode ? y_wide : {{EXT_W{y_nar[REG_W-1]}}, y_nar};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      result <= '0;
      else if (writes) result <= res_next;
   end

   sovf_sticky u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(ovf_hit), .clr_i(br_test), .q(ovf_flag)
   );

   genvar gb;
   generate
      for (gb = 0; gb < STAT_W; gb++) begin : g_stat
         if (gb == FLAG_POS) begin : g_flag_bit
            assign status_word[gb] = ovf_flag;
         end else begin : g_zero_bit
            assign status_word[gb] = 1'b0;
         end
      end
   endgenerate

   assert_cmp_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_CMP) |=> $stable(result));
   assert_cmp_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_CMP && !br_test) |=> $stable(ovf_flag));
   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !br_test) |=> ($stable(result) && $stable(ovf_flag)));
   assert_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(status_word) == (ovf_flag ? 1 : 0)) && (status_word[FLAG_POS] == ovf_flag));
   assert_narrow_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op != OP_CMP && !wide_mode) |=>
      (result[ACC_W-1:REG_W] == {EXT_W{result[REG_W-1]}}));
endmodule

// File: tb/sticky_ovf_alu_tb.sv
module sticky_ovf_alu_tb;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_code = 2'b00;
   logic        wide_mode = 1'b1;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        br_test = 1'b0;
   logic [31:0] result;
   logic        ovf_flag;
   logic [15:0] status_word;

   always #(CLK_PERIOD/2) clk = ~clk;

   sticky_ovf_alu u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .wide_mode(wide_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .br_test(br_test), .result(result), .ovf_flag(ovf_flag),
      .status_word(status_word)
   );

   typedef struct {
      logic [31:0] res;
      logic        flag;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          n_chk = 0;
   int          n_bad = 0;
   logic [31:0] m_res = '0;
   logic        m_flag = 1'b0;
   bit          done = 1'b0;

   task automatic check(input string tag, input logic [31:0] r, input logic f,
                        input logic [15:0] s, input logic [31:0] er, input logic ef);
      logic [15:0] es;
      es = {9'b0, ef, 6'b0};
      n_chk++;
      if (r !== er || f !== ef || s !== es) begin
         n_bad++;
         $display("FAIL %s: result=%h flag=%b status=%h expected result=%h flag=%b status=%h",
                  tag, r, f, s, er, ef, es);
      end
   endtask

   function automatic void model(input logic [1:0] op, input logic wide,
                                 input logic [31:0] a, input logic [31:0] b,
                                 output logic [31:0] r, output bit ov);
      longint sa, sb, f, lo, hi;
      if (wide) begin
         sa = longint'($signed(a));
         sb = longint'($signed(b));
         lo = -(64'sd1 <<< 31); hi = (64'sd1 <<< 31) - 1;
      end else begin
         sa = longint'($signed(a[15:0]));
         sb = longint'($signed(b[15:0]));
         lo = -(64'sd1 <<< 15); hi = (64'sd1 <<< 15) - 1;
      end
      case (op)
         2'b00:   f = sa + sb;
         2'b01:   f = sa - sb;
         default: f = (sa < 0) ? -sa : sa;
      endcase
      ov = (f < lo) || (f > hi);
      r  = wide ? f[31:0] : {{16{f[15]}}, f[15:0]};
   endfunction

   task automatic drive(input string tag, input logic v, input logic [1:0] op,
                        input logic wide, input logic [31:0] a, input logic [31:0] b,
                        input logic br);
      logic [31:0] r;
      bit          ov;
      exp_t        e;
      @(negedge clk);
      op_valid = v; op_code = op; wide_mode = wide;
      opnd_a = a; opnd_b = b; br_test = br;
      ov = 1'b0;
      if (v && op != 2'b11) begin
         model(op, wide, a, b, r, ov);
         m_res = r;
      end
      if (br)      m_flag = 1'b0;
      else if (ov) m_flag = 1'b1;
      e.res = m_res; e.flag = m_flag; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic idle(input string tag);
      drive(tag, 1'b0, 2'b00, 1'b1, 32'h0, 32'h0, 1'b0);
   endtask

   always @(posedge clk) begin
      #1ns;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(e.tag, result, ovf_flag, status_word, e.res, e.flag);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: result=%h expected completion", result);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 2);
      check("R9 reset", result, ovf_flag, status_word, 32'h0, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      idle("R9 idle after reset");
      drive("R1 add no ovf",      1, 2'b00, 1, 32'h1, 32'h2, 0);
      drive("R1 add pos ovf",     1, 2'b00, 1, 32'h7FFF_FFFF, 32'h1, 0);
      drive("R4 add fits, sticky",1, 2'b00, 1, 32'h5, 32'h6, 0);
      idle("R4 idle sticky R8");
      drive("R1 add neg ovf keeps",1, 2'b00, 1, 32'h8000_0000, 32'hFFFF_FFFF, 0);
      drive("R5 br clear",        0, 2'b00, 1, 32'h0, 32'h0, 1);
      drive("R5 br on clear flag",0, 2'b00, 1, 32'h0, 32'h0, 1);
      drive("R2 sub no ovf",      1, 2'b01, 1, 32'h10, 32'h30, 0);
      drive("R2 sub ovf",         1, 2'b01, 1, 32'h8000_0000, 32'h1, 0);
      drive("R5 clear",           0, 2'b00, 1, 32'h0, 32'h0, 1);
      drive("R2 sub pos ovf",     1, 2'b01, 1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0);
      drive("R5 clear again",     0, 2'b00, 1, 32'h0, 32'h0, 1);
      drive("R3 wide no ovf",     1, 2'b00, 1, 32'h7FFF, 32'h1, 0);
      drive("R3 narrow ovf",      1, 2'b00, 0, 32'h1234_7FFF, 32'hABCD_0001, 0);
      drive("R5 clear narrow",    0, 2'b00, 0, 32'h0, 32'h0, 1);
      drive("R3 narrow neg fits", 1, 2'b00, 0, 32'h0000_FFF0, 32'h0000_0005, 0);
      drive("R3 narrow sub ovf",  1, 2'b01, 0, 32'h0000_8000, 32'h0000_0001, 0);
      drive("R5 clear beats ovf", 1, 2'b00, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1);
      drive("R6 cmp flag0",       1, 2'b11, 1, 32'h7FFF_FFFF, 32'h8000_0000, 0);
      drive("R6 cmp narrow",      1, 2'b11, 0, 32'h0000_7FFF, 32'h0000_8000, 0);
      drive("R7 abs min",         1, 2'b10, 1, 32'h8000_0000, 32'h0, 0);
      drive("R6 cmp flag1",       1, 2'b11, 1, 32'h8000_0000, 32'h1, 0);
      drive("R5 clear",           0, 2'b00, 1, 32'h0, 32'h0, 1);
      drive("R7 abs neg",         1, 2'b10, 1, 32'hFFFF_FFFB, 32'h0, 0);
      drive("R7 abs pos",         1, 2'b10, 1, 32'h0000_1234, 32'h0, 0);
      drive("R7 abs narrow min",  1, 2'b10, 0, 32'h5555_8000, 32'h0, 0);
      drive("R5 clear",           0, 2'b00, 1, 32'h0, 32'h0, 1);
      drive("R7 abs narrow neg",  1, 2'b10, 0, 32'h0000_FFFF, 32'h0, 0);
      drive("R10 invalid ovf op", 0, 2'b00, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0);
      drive("R10 invalid abs",    0, 2'b10, 0, 32'h0000_8000, 32'h0, 0);
      idle("R8 final idle");
      idle("R8 drain");
      repeat (3) @(posedge clk);
      #2ns;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule